// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a 16-bit up-counter that never halts once reset is released. A programmable divider sets how often it advances, from every clock down to every 32nd clock. Eight compare channels each hold a 16-bit target. When the counter steps onto a channel's target, that channel's event flag is set. A separate flag records each wrap from all ones to zero.

Software reaches the block over a single-cycle register bus. Writes are synchronous and reads are combinational from the address. Flags are acknowledged by writing ones, and the divider ratio can be changed at any moment. Two interrupt request lines leave the block. One carries the wrap event. The other is the OR of every compare channel whose flag and enable are both set.

Top module: `oc_timer`

## Requirements
- R1: The count is 16 bits, is 0x0000 after reset, advances by exactly one on each prescaler tick, wraps from 0xFFFF to 0x0000, and is read at address 5. Writes to address 5 have no effect.
- R2: The rate field is bits [2:0] at address 0. A code n from 0 to 5 advances the count once every 2^n clocks, and codes 6 and 7 behave as 5. Ticks come from a 5-bit divider that runs from reset and is never cleared. A tick falls in each cycle where the divider's low n bits are all ones. A new code applies from the cycle after the write.
- R3: For compare channel i (0 to 7), flag bit i at address 2 is set in the same edge at which the count advances onto the value held at address 8+i. While the count rests on that value, the flag is not set again.
- R4: Bit 7 at address 4 is set in the same edge at which the count advances from 0xFFFF to 0x0000.
- R5: Writing 1 to a flag bit at address 2 or bit 7 at address 4 clears that flag. Writing 0 leaves it unchanged.
- R6: If a set event and a clearing write hit the same flag in one cycle, the flag ends up set.
- R7: `ovf_irq_o` is high exactly when the wrap flag and the wrap enable (bit 7 at address 3) are both 1.
- R8: `cmp_irq_o` is high exactly when some channel i has flag bit i at address 2 and enable bit i at address 1 both set.
- R9: After reset, every register reads zero, except address 5 once it has started counting. Address 0 reads back bits [2:0], address 1 reads back bits [7:0], address 3 reads back bit 7, and addresses 8 to 15 read back all 16 bits. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for this cycle |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| ovf_irq_o | output | 1 | Wrap interrupt request |
| cmp_irq_o | output | 1 | Combined compare interrupt request |

## Verification
The properties assume that `wr_i`, `addr_i` and `wdata_i` are settled at each rising edge and hold one request per cycle. They do not assume any timing between writes and counter ticks, so a clear may land on a match cycle.

The stimulus drives the bus only on falling edges. It deliberately issues clears in every cycle while a match approaches, which lets it hit the collision case. It moves the rate code through all eight values while the counter is running.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;
  localparam int A_CTRL     = 0;
  localparam int A_CMP_EN   = 1;
  localparam int A_CMP_FLAG = 2;
  localparam int A_OVF_EN   = 3;
  localparam int A_OVF_FLAG = 4;
  localparam int A_COUNT    = 5;
  localparam int A_CMP_BASE = 8;
  localparam int OVF_BIT    = 7;
endpackage

// File: rtl/oc_prescaler.sv
module oc_prescaler #(
  parameter int PS_W  = 3,
  parameter int DIV_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int SH_W = $clog2(DIV_W + 1);

  logic [DIV_W-1:0] div_q;
  logic [SH_W-1:0]  sh;
  logic [DIV_W:0]   full;
  logic [DIV_W-1:0] mask;

  // codes above the divider depth saturate at the slowest rate
  always_comb begin
    if (int'(sel_i) > DIV_W) sh = SH_W'(DIV_W);
    else                     sh = SH_W'(sel_i);
    full = ((DIV_W+1)'(1) << sh) - (DIV_W+1)'(1);
    mask = full[DIV_W-1:0];
  end

  assign tick_o = (div_q & mask) == mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign nxt_o  = cnt_q + CNT_W'(1);
  assign wrap_o = adv_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= nxt_o;
  end
endmodule

// File: rtl/oc_cmp_bank.sv
module oc_cmp_bank #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CH-1:0]            we_i,
  input  logic [CNT_W-1:0]           wdata_i,
  input  logic                       adv_i,
  input  logic [CNT_W-1:0]           nxt_i,
  output logic [N_CH-1:0][CNT_W-1:0] val_o,
  output logic [N_CH-1:0]            hit_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [CNT_W-1:0] val_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      val_q <= '0;
      else if (we_i[g]) val_q <= wdata_i;
    end

    // match is judged on the value being entered, once per advance
    assign hit_o[g] = adv_i && (nxt_i == val_q);
    assign val_o[g] = val_q;
  end
endmodule

// File: rtl/oc_w1c_flags.sv
module oc_w1c_flags #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;  // set dominates
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CH   = 8,
  parameter int PS_W   = 3,
  parameter int DIV_W  = 5,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_irq_o,
  output logic              cmp_irq_o
);
  logic [PS_W-1:0]            ps_q;
  logic [N_CH-1:0]            cmp_en_q;
  logic                       ovf_en_q;
  logic                       tick;
  logic [CNT_W-1:0]           cnt;
  logic [CNT_W-1:0]           cnt_nxt;
  logic                       wrap;
  logic [N_CH-1:0]            cmp_we;
  logic [N_CH-1:0]            cmp_hit;
  logic [N_CH-1:0][CNT_W-1:0] cmp_val;
  logic [N_CH-1:0]            cmp_clr;
  logic [N_CH-1:0]            cmp_flag;
  logic                       ovf_clr;
  logic                       ovf_flag;

  logic wr_ctrl, wr_cmp_en, wr_cmp_flag, wr_ovf_en, wr_ovf_flag;
  assign wr_ctrl     = wr_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_cmp_en   = wr_i && (addr_i == ADDR_W'(A_CMP_EN));
  assign wr_cmp_flag = wr_i && (addr_i == ADDR_W'(A_CMP_FLAG));
  assign wr_ovf_en   = wr_i && (addr_i == ADDR_W'(A_OVF_EN));
  assign wr_ovf_flag = wr_i && (addr_i == ADDR_W'(A_OVF_FLAG));

  for (genvar g = 0; g < N_CH; g++) begin : g_we
    assign cmp_we[g] = wr_i && (addr_i == ADDR_W'(A_CMP_BASE + g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q     <= '0;
      cmp_en_q <= '0;
      ovf_en_q <= 1'b0;
    end else begin
      if (wr_ctrl)   ps_q     <= wdata_i[PS_W-1:0];
      if (wr_cmp_en) cmp_en_q <= wdata_i[N_CH-1:0];
      if (wr_ovf_en) ovf_en_q <= wdata_i[OVF_BIT];
    end
  end

  oc_prescaler #(.PS_W(PS_W), .DIV_W(DIV_W)) u_ps (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (ps_q),
    .tick_o(tick)
  );

  oc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (tick),
    .cnt_o (cnt),
    .nxt_o (cnt_nxt),
    .wrap_o(wrap)
  );

  oc_cmp_bank #(.N_CH(N_CH), .CNT_W(CNT_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cmp_we),
    .wdata_i(wdata_i[CNT_W-1:0]),
    .adv_i  (tick),
    .nxt_i  (cnt_nxt),
    .val_o  (cmp_val),
    .hit_o  (cmp_hit)
  );

  assign cmp_clr = wr_cmp_flag ? wdata_i[N_CH-1:0] : '0;
  assign ovf_clr = wr_ovf_flag && wdata_i[OVF_BIT];

  oc_w1c_flags #(.W(N_CH)) u_cmp_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (cmp_hit),
    .clr_i (cmp_clr),
    .flag_o(cmp_flag)
  );

  oc_w1c_flags #(.W(1)) u_ovf_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wrap),
    .clr_i (ovf_clr),
    .flag_o(ovf_flag)
  );

  assign ovf_irq_o = ovf_flag && ovf_en_q;
  assign cmp_irq_o = |(cmp_flag & cmp_en_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CTRL):     rdata_o[PS_W-1:0] = ps_q;
      ADDR_W'(A_CMP_EN):   rdata_o[N_CH-1:0] = cmp_en_q;
      ADDR_W'(A_CMP_FLAG): rdata_o[N_CH-1:0] = cmp_flag;
      ADDR_W'(A_OVF_EN):   rdata_o[OVF_BIT]  = ovf_en_q;
      ADDR_W'(A_OVF_FLAG): rdata_o[OVF_BIT]  = ovf_flag;
      ADDR_W'(A_COUNT):    rdata_o[CNT_W-1:0] = cnt;
      default: begin
        for (int i = 0; i < N_CH; i++)
          if (addr_i == ADDR_W'(A_CMP_BASE + i)) rdata_o[CNT_W-1:0] = cmp_val[i];
      end
    endcase
  end
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk
  import oc_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CH   = 8,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [PS_W-1:0]   ps_q,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [N_CH-1:0]   cmp_flag,
  input logic [N_CH-1:0]   cmp_en_q,
  input logic              ovf_flag,
  input logic              ovf_en_q,
  input logic              ovf_irq_o,
  input logic              cmp_irq_o
);
  logic [N_CH-1:0] keep_mask;
  logic            ovf_keep;
  assign keep_mask = (wr_i && addr_i == ADDR_W'(A_CMP_FLAG)) ? ~wdata_i[N_CH-1:0] : '1;
  assign ovf_keep  = !(wr_i && addr_i == ADDR_W'(A_OVF_FLAG) && wdata_i[OVF_BIT]);

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> cnt == $past(cnt) + CNT_W'(1));

  p_cnt_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt));

  p_full_rate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_q == '0) |-> tick);

  p_no_cmp_set_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> ((cmp_flag & ~$past(cmp_flag)) == '0));

  p_ovf_on_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (&cnt)) |=> ovf_flag);

  p_cmp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cmp_flag & $past(cmp_flag & keep_mask)) == $past(cmp_flag & keep_mask)));

  p_ovf_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag && ovf_keep) |=> ovf_flag);

  p_ovf_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_en_q |-> !ovf_irq_o);

  p_cmp_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_irq_o |-> ((cmp_flag & cmp_en_q) != '0));
endmodule

bind oc_timer oc_timer_chk #(
  .CNT_W(CNT_W), .N_CH(N_CH), .PS_W(PS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .ps_q     (ps_q),
  .tick     (tick),
  .cnt      (cnt),
  .cmp_flag (cmp_flag),
  .cmp_en_q (cmp_en_q),
  .ovf_flag (ovf_flag),
  .ovf_en_q (ovf_en_q),
  .ovf_irq_o(ovf_irq_o),
  .cmp_irq_o(cmp_irq_o)
);

// File: tb/tb_oc_timer.sv
module tb_oc_timer;
  localparam int AD_CTRL = 0, AD_EN = 1, AD_FLAG = 2, AD_OEN = 3, AD_OFLAG = 4, AD_CNT = 5, AD_CMP = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ovf_irq_o, cmp_irq_o;

  oc_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ovf_irq_o(ovf_irq_o), .cmp_irq_o(cmp_irq_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt, m_div, m_ps, m_en, m_flag, m_oen, m_oflag;
  int m_cmp[8];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_div = 0; m_ps = 0; m_en = 0; m_flag = 0; m_oen = 0; m_oflag = 0;
      foreach (m_cmp[k]) m_cmp[k] = 0;
    end else begin
      int sh, mask, nxt, setv, oset;
      bit tk;
      sh = (m_ps > 5) ? 5 : m_ps;
      mask = (1 << sh) - 1;
      tk = ((m_div & mask) == mask);
      nxt = (m_cnt + 1) & 16'hFFFF;
      setv = 0; oset = 0;
      if (tk) begin
        if (m_cnt == 16'hFFFF) oset = 1;
        for (int k = 0; k < 8; k++) if (m_cmp[k] == nxt) setv |= (1 << k);
      end
      if (wr_i && addr_i == 4'(AD_FLAG)) m_flag &= ~int'(wdata_i[7:0]);
      if (wr_i && addr_i == 4'(AD_OFLAG) && wdata_i[7]) m_oflag = 0;
      m_flag |= setv;
      if (oset) m_oflag = 1;
      if (wr_i) begin
        if (addr_i == 4'(AD_CTRL)) m_ps = int'(wdata_i[2:0]);
        if (addr_i == 4'(AD_EN))   m_en = int'(wdata_i[7:0]);
        if (addr_i == 4'(AD_OEN))  m_oen = int'(wdata_i[7]);
        if (addr_i >= 4'(AD_CMP))  m_cmp[int'(addr_i) - AD_CMP] = int'(wdata_i);
      end
      if (tk) m_cnt = nxt;
      m_div = (m_div + 1) & 31;
    end
  end

  function automatic int m_read(int a);
    case (a)
      AD_CTRL:  return m_ps;
      AD_EN:    return m_en;
      AD_FLAG:  return m_flag;
      AD_OEN:   return m_oen << 7;
      AD_OFLAG: return m_oflag << 7;
      AD_CNT:   return m_cnt;
      default:  return (a >= AD_CMP) ? m_cmp[a - AD_CMP] : 0;
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      AD_CTRL: return "R2";
      AD_FLAG: return "R3";
      AD_OFLAG: return "R4";
      AD_CNT:  return "R1";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check(req_of(int'(addr_i)), int'(rdata_o), m_read(int'(addr_i)));
    check("R7", int'(ovf_irq_o), (m_oflag != 0 && m_oen != 0) ? 1 : 0);
    check("R8", int'(cmp_irq_o), ((m_flag & m_en) != 0) ? 1 : 0);
  endtask

  // one clock: compare at falling edge, then drive the next request
  task automatic step(bit w, int a, int d);
    @(negedge clk_i);
    compare_all();
    wr_i = w; addr_i = 4'(a); wdata_i = 16'(d);
  endtask

  task automatic rd(int a); step(0, a, 0); endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset values and read-back of every address
    for (int a = 0; a < 16; a++) rd(a);
    @(negedge clk_i);
    check("R9", int'(rdata_o), 0);

    // program compares and enables (R9 read-back)
    for (int k = 0; k < 8; k++) step(1, AD_CMP + k, 40 + 13 * k);
    step(1, AD_EN, 8'hA5);
    step(1, AD_OEN, 16'h0080);
    for (int a = 0; a < 16; a++) rd(a);
    repeat (160) rd(AD_FLAG);
    // R5: writing zeros leaves flags; ones clear
    step(1, AD_FLAG, 0);
    rd(AD_FLAG);
    @(negedge clk_i);
    check("R5", int'(rdata_o[7:0]), 8'hFF);
    step(1, AD_FLAG, 8'h0F);
    rd(AD_FLAG);
    @(negedge clk_i);
    check("R5", int'(rdata_o[7:0]), 8'hF0);
    step(1, AD_FLAG, 8'hFF);

    // R2: sweep every rate code while running
    for (int p = 0; p < 8; p++) begin
      step(1, AD_CTRL, p);
      repeat (90) rd(AD_CNT);
      step(1, AD_CNT, 16'h1234);  // R1: ignored write
      repeat (10) rd(AD_CNT);
    end

    // R3: slow rate, flag set once per value
    step(1, AD_CTRL, 5);
    step(1, AD_CMP + 3, (m_cnt + 2) & 16'hFFFF);
    step(1, AD_FLAG, 8'hFF);
    seen = 0;
    for (int t = 0; t < 200 && seen == 0; t++) begin
      rd(AD_FLAG);
      if (m_flag[3]) seen = 1;
    end
    step(1, AD_FLAG, 8'h08);
    repeat (4) rd(AD_FLAG);
    @(negedge clk_i);
    check("R3", int'(rdata_o[3]), 0);
    check("R3", seen, 1);

    // R6: clear written every cycle while a match arrives at full rate
    step(1, AD_CTRL, 0);
    step(1, AD_CMP + 2, (m_cnt + 12) & 16'hFFFF);
    seen = 0;
    for (int t = 0; t < 30; t++) begin
      step(1, AD_FLAG, 8'hFF);
      if (rdata_o[2]) seen = 1;
    end
    check("R6", seen, 1);

    // R4/R7: run to wrap at full rate
    step(0, AD_OFLAG, 0);
    for (int t = 0; t < 70000 && m_oflag == 0; t++) rd(AD_OFLAG);
    rd(AD_OFLAG);
    @(negedge clk_i);
    check("R4", int'(rdata_o[7]), 1);
    check("R7", int'(ovf_irq_o), 1);
    step(1, AD_OEN, 0);
    rd(AD_CNT);
    @(negedge clk_i);
    check("R7", int'(ovf_irq_o), 0);
    step(1, AD_OFLAG, 16'h0080);
    step(1, AD_EN, 0);
    repeat (5) rd(AD_OFLAG);
    @(negedge clk_i);
    check("R8", int'(cmp_irq_o), 0);
    compare_all();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule